// File: doc/BRIEF.md
# Write Violation Log Capture Queue

This block sits beside a bus protection checker and keeps a record of every write that the checker refuses. For each refused write it stores the burst attributes (type, length, size, protection bits), the initiator identifier, the full target address and the first beat of write data. Records go into a small first-in first-out queue. Software sees the oldest record through a read-only window of 32-bit CSR words.

A write-violation interrupt flag rises whenever a record is accepted. A pulse on the clear input lowers it. The log-valid bit in the status word is true only while the queue holds a record and the interrupt flag is up.

Software drains the queue by reading the words of the head record. The read of the highest data word that carries information for the configured data width removes the head record. Software keeps reading until the valid bit reads zero. A refused write that arrives while the queue is full is discarded, and a sticky overflow flag records the loss.

Top module: `wviol_log_queue`

## Requirements
- R1: The status word at offset 0x190 packs the head record as bit 0 = log-valid, bits 3:1 = protection, bits 6:4 = burst size, bits 10:7 = burst length, bits 12:11 = burst type, and bits 31:13 read zero.
- R2: Offset 0x194 returns the initiator ID zero-extended. Offset 0x198 returns address bits 31:0 and 0x19C returns address bits 63:32. Offsets 0x1A0, 0x1A4, 0x1A8 and 0x1AC return write-data bits 31:0, 63:32, 95:64 and 127:96. Any other offset reads zero. Read data and `csr_rd_vld` appear on the clock edge after the cycle in which `csr_rd_en` is high.
- R3: A read of offset 0x1A0 + 4*(DATA_W/32 - 1) removes the head record (0x1AC when DATA_W = 128, 0x1A0 when DATA_W = 32). A read of any other offset leaves the queue unchanged.
- R4: When ADDR_W is 32 or less, offset 0x19C reads zero. Data words that lie above DATA_W read zero.
- R5: Records leave in arrival order, and up to DEPTH records are held. A violation that arrives while the queue is full, with no removal in the same cycle, is dropped and sets `log_ovf`. `log_ovf` stays set until `irq_clr`.
- R6: A violation and a removing read in the same cycle leave the occupancy unchanged. The new record is kept even when the queue is full, and `log_ovf` is not set.
- R7: `wr_viol_irq` sets on the edge that accepts a record and clears on the edge after `irq_clr` is high. If both happen in the same cycle, set wins. `irq_clr` also clears `log_ovf`.
- R8: The valid bit equals (queue not empty) AND `wr_viol_irq`. Clearing the interrupt hides validity but keeps the queued records.
- R9: After reset the flags are low and every word reads zero. While the queue is empty, all words read zero and a removing read has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| viol_stb | input | 1 | One-cycle strobe for a refused write |
| viol_btype | input | 2 | Burst type of the refused write |
| viol_blen | input | 4 | Burst length of the refused write |
| viol_bsize | input | 3 | Burst size of the refused write |
| viol_prot | input | 3 | Protection bits of the refused write |
| viol_id | input | ID_W | Initiator identifier |
| viol_addr | input | ADDR_W | Target address |
| viol_wdata | input | DATA_W | First write-data beat |
| irq_clr | input | 1 | Clears the interrupt and overflow flags |
| csr_rd_en | input | 1 | CSR read request, always accepted |
| csr_rd_addr | input | 12 | Byte offset of the CSR read |
| csr_rd_data | output | 32 | Registered read data |
| csr_rd_vld | output | 1 | Read data valid |
| wr_viol_irq | output | 1 | Write-violation interrupt flag |
| log_ovf | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can fall in the same cycle: a capture and a removing read, and a capture and an interrupt clear. The bench fills the queue to DEPTH and then, in one cycle, drives a strobe together with a read of the removing offset. It then judges the returned word, checks that the overflow flag stays low, and checks that the remaining records come out in arrival order with the new record last. In a separate cycle it drives a strobe together with `irq_clr` and checks that the interrupt stays high and that the valid bit still reads one.

// File: rtl/wviol_pkg.sv
// Package: shared offsets and attribute layout for the write violation log.
// Assumes a 12-bit byte offset space for the CSR window.
package wviol_pkg;

    localparam logic [11:0] OFS_STAT = 12'h190;
    localparam logic [11:0] OFS_ID   = 12'h194;
    localparam logic [11:0] OFS_ALO  = 12'h198;
    localparam logic [11:0] OFS_AHI  = 12'h19C;
    localparam logic [11:0] OFS_D0   = 12'h1A0;
    localparam logic [11:0] OFS_D1   = 12'h1A4;
    localparam logic [11:0] OFS_D2   = 12'h1A8;
    localparam logic [11:0] OFS_D3   = 12'h1AC;

    localparam int NUM_SLICES = 4;

    typedef struct packed {
        logic [1:0] btype;
        logic [3:0] blen;
        logic [2:0] bsize;
        logic [2:0] prot;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    // Offset of the last data word that carries information for a width.
    function automatic logic [11:0] pop_offset(input int data_w);
        return OFS_D0 + 12'(4 * (data_w / 32 - 1));
    endfunction

endpackage

// File: rtl/wviol_fifo.sv
// Module: record queue. Keeps up to DEPTH records of WIDTH bits in order.
// Assumes push and pop are single-cycle requests. A pop on an empty queue
// is ignored. A push on a full queue is taken only if a pop happens in the
// same cycle.
module wviol_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             accept
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop;
    logic             do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Decide which requests take effect this cycle.
    always_comb begin
        empty   = (count == '0);
        full    = (count == FULL_CNT);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        accept  = do_push;
        dout    = mem[rd_ptr];
    end

    // Store the incoming record at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);                                              // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> full);                                  // R5
    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !empty |=> $stable(count));                       // R6
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push |=> empty);                                // R9

endmodule

// File: rtl/wviol_irq.sv
// Module: interrupt and overflow flags.
// The interrupt sets on an accepted record. The overflow flag sets on a
// dropped record. A clear pulse lowers both, and a set in the same cycle wins.
module wviol_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic captured,
    input  logic dropped,
    input  logic clr,
    output logic irq,
    output logic ovf
);
    // Update the interrupt flag, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (captured) irq <= 1'b1;
        else if (clr)      irq <= 1'b0;
    end

    // Update the sticky overflow flag, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (dropped) ovf <= 1'b1;
        else if (clr)     ovf <= 1'b0;
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        captured |=> irq);                                               // R7
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !captured |=> !irq);                                      // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr |=> ovf);                                            // R5

endmodule

// File: rtl/wviol_csr_view.sv
// Module: read-only CSR window onto the head record.
// Assumes DATA_W is a multiple of 32 no larger than 128, ADDR_W <= 64 and
// ID_W <= 32. Read data is registered. Every word reads zero while empty.
module wviol_csr_view
    import wviol_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 128,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  attr_t             head_attr,
    input  logic [ID_W-1:0]   head_id,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    input  logic              empty,
    input  logic              irq,
    input  logic              rd_en,
    input  logic [11:0]       rd_addr,
    output logic              pop,
    output logic [31:0]       rd_data,
    output logic              rd_vld
);
    localparam logic [11:0] POP_OFS = pop_offset(DATA_W);

    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] slice [NUM_SLICES];
    logic [31:0] stat_w;
    logic [31:0] word;
    logic        valid;

    // Split the address into two words. The high word is zero for narrow systems.
    generate
        if (ADDR_W > 32) begin : g_wide_addr
            assign addr_lo = head_addr[31:0];
            assign addr_hi = 32'(head_addr[ADDR_W-1:32]);
        end else begin : g_narrow_addr
            assign addr_lo = 32'(head_addr);
            assign addr_hi = '0;
        end
    endgenerate

    // Cut the data beat into 32-bit words. Words above DATA_W are zero.
    generate
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            if (s * 32 < DATA_W) begin : g_live
                assign slice[s] = head_data[s*32 +: 32];
            end else begin : g_dead
                assign slice[s] = '0;
            end
        end
    endgenerate

    // Build the status word and select the addressed word.
    always_comb begin
        valid  = !empty && irq;
        stat_w = {19'b0, head_attr.btype, head_attr.blen,
                  head_attr.bsize, head_attr.prot, valid};
        case (rd_addr)
            OFS_STAT: word = stat_w;
            OFS_ID:   word = 32'(head_id);
            OFS_ALO:  word = addr_lo;
            OFS_AHI:  word = addr_hi;
            OFS_D0:   word = slice[0];
            OFS_D1:   word = slice[1];
            OFS_D2:   word = slice[2];
            OFS_D3:   word = slice[3];
            default:  word = '0;
        endcase
        if (empty) word = '0;
        pop = rd_en && (rd_addr == POP_OFS);
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_data <= rd_en ? word : '0;
            rd_vld  <= rd_en;
        end
    end

    AST_VALID_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr == OFS_STAT && !irq |=> rd_data[0] == 1'b0);    // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr == OFS_STAT |=> rd_data[31:13] == '0);          // R1
    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);                                               // R2
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && empty |=> rd_data == '0);                               // R9

endmodule

// File: rtl/wviol_log_queue.sv
// Module: top of the write violation log. Packs each refused write into a
// record, queues it, keeps the interrupt and overflow flags, and serves the
// head record through the CSR window. Assumes viol_stb lasts one cycle per
// refused write and that CSR reads are always accepted.
module wviol_log_queue
    import wviol_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 64,
    parameter int DATA_W = 128,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol_stb,
    input  logic [1:0]        viol_btype,
    input  logic [3:0]        viol_blen,
    input  logic [2:0]        viol_bsize,
    input  logic [2:0]        viol_prot,
    input  logic [ID_W-1:0]   viol_id,
    input  logic [ADDR_W-1:0] viol_addr,
    input  logic [DATA_W-1:0] viol_wdata,
    input  logic              irq_clr,
    input  logic              csr_rd_en,
    input  logic [11:0]       csr_rd_addr,
    output logic [31:0]       csr_rd_data,
    output logic              csr_rd_vld,
    output logic              wr_viol_irq,
    output logic              log_ovf
);
    localparam int ENTRY_W = ATTR_W + ID_W + ADDR_W + DATA_W;

    attr_t              in_attr;
    attr_t              head_attr;
    logic [ID_W-1:0]    head_id;
    logic [ADDR_W-1:0]  head_addr;
    logic [DATA_W-1:0]  head_data;
    logic [ENTRY_W-1:0] in_rec;
    logic [ENTRY_W-1:0] head_rec;
    logic               q_empty;
    logic               q_full;
    logic               q_accept;
    logic               q_pop;
    logic               dropped;

    // Pack the incoming attributes into a record and unpack the head record.
    always_comb begin
        in_attr = '{btype: viol_btype, blen: viol_blen,
                    bsize: viol_bsize, prot: viol_prot};
        in_rec  = {in_attr, viol_id, viol_addr, viol_wdata};
        {head_attr, head_id, head_addr, head_data} = head_rec;
        dropped = viol_stb && !q_accept;
    end

    wviol_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (viol_stb),
        .pop    (q_pop),
        .din    (in_rec),
        .dout   (head_rec),
        .empty  (q_empty),
        .full   (q_full),
        .accept (q_accept)
    );

    wviol_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .captured (q_accept),
        .dropped  (dropped),
        .clr      (irq_clr),
        .irq      (wr_viol_irq),
        .ovf      (log_ovf)
    );

    wviol_csr_view #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ID_W   (ID_W)
    ) u_view (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_attr (head_attr),
        .head_id   (head_id),
        .head_addr (head_addr),
        .head_data (head_data),
        .empty     (q_empty),
        .irq       (wr_viol_irq),
        .rd_en     (csr_rd_en),
        .rd_addr   (csr_rd_addr),
        .pop       (q_pop),
        .rd_data   (csr_rd_data),
        .rd_vld    (csr_rd_vld)
    );

    AST_FULL_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        viol_stb && q_full && q_pop |=> !log_ovf || $past(log_ovf));     // R6
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        viol_stb && q_full && !q_pop |=> log_ovf);                       // R5

endmodule

// File: tb/tb_wviol_log_queue.sv
module tb_wviol_log_queue;

    typedef struct packed {
        logic [1:0]   bt;
        logic [3:0]   bl;
        logic [2:0]   bs;
        logic [2:0]   pr;
        logic [7:0]   id;
        logic [63:0]  ad;
        logic [127:0] wd;
    } rec_t;

    localparam rec_t VEC [4] = '{
        '{2'd1, 4'd3, 3'd2, 3'd5, 8'h11, 64'h1234_5678_9ABC_DEF0,
          128'h0F0E0D0C_0B0A0908_07060504_03020100},
        '{2'd2, 4'd15, 3'd7, 3'd0, 8'hA5, 64'h0000_0001_8000_0000,
          128'hFFFFFFFF_00000000_AAAAAAAA_55555555},
        '{2'd3, 4'd0, 3'd0, 3'd7, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFC,
          128'h11111111_22222222_33333333_44444444},
        '{2'd0, 4'd9, 3'd4, 3'd2, 8'h3C, 64'h0000_0000_0000_0040,
          128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF}
    };
    localparam rec_t EXTRA = '{2'd2, 4'd6, 3'd1, 3'd3, 8'h77,
        64'h5555_0000_AAAA_0000, 128'h99999999_88888888_77777777_66666666};
    localparam logic [11:0] OFS [8] = '{12'h190, 12'h194, 12'h198, 12'h19C,
                                         12'h1A0, 12'h1A4, 12'h1A8, 12'h1AC};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    rec_t         cur = '0;
    logic         stb = 1'b0, clr = 1'b0, rd = 1'b0;
    logic [11:0]  ra = '0;
    logic [31:0]  rdata;
    logic         rvld, irq, ovf;
    logic [31:0]  last;

    logic         n_stb = 1'b0, n_rd = 1'b0;
    logic [11:0]  n_ra = '0;
    logic [31:0]  n_rdata;
    logic         n_rvld, n_irq, n_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wviol_log_queue dut (
        .clk(clk), .rst_n(rst_n), .viol_stb(stb),
        .viol_btype(cur.bt), .viol_blen(cur.bl), .viol_bsize(cur.bs),
        .viol_prot(cur.pr), .viol_id(cur.id), .viol_addr(cur.ad),
        .viol_wdata(cur.wd), .irq_clr(clr), .csr_rd_en(rd),
        .csr_rd_addr(ra), .csr_rd_data(rdata), .csr_rd_vld(rvld),
        .wr_viol_irq(irq), .log_ovf(ovf)
    );

    wviol_log_queue #(.DEPTH(2), .ADDR_W(32), .DATA_W(32), .ID_W(8)) dut32 (
        .clk(clk), .rst_n(rst_n), .viol_stb(n_stb),
        .viol_btype(VEC[0].bt), .viol_blen(VEC[0].bl), .viol_bsize(VEC[0].bs),
        .viol_prot(VEC[0].pr), .viol_id(VEC[0].id), .viol_addr(VEC[0].ad[31:0]),
        .viol_wdata(VEC[0].wd[31:0]), .irq_clr(1'b0), .csr_rd_en(n_rd),
        .csr_rd_addr(n_ra), .csr_rd_data(n_rdata), .csr_rd_vld(n_rvld),
        .wr_viol_irq(n_irq), .log_ovf(n_ovf)
    );

    function automatic logic [31:0] expw(rec_t r, logic [11:0] o, bit v);
        case (o)
            12'h190: return {19'b0, r.bt, r.bl, r.bs, r.pr, v};
            12'h194: return {24'b0, r.id};
            12'h198: return r.ad[31:0];
            12'h19C: return r.ad[63:32];
            12'h1A0: return r.wd[31:0];
            12'h1A4: return r.wd[63:32];
            12'h1A8: return r.wd[95:64];
            12'h1AC: return r.wd[127:96];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, sample at the next falling edge.
    task automatic step(bit s, rec_t r, bit c, bit rdo, logic [11:0] a);
        stb = s; cur = r; clr = c; rd = rdo; ra = a;
        @(negedge clk);
        last = rdata;
        stb = 1'b0; clr = 1'b0; rd = 1'b0;
    endtask

    task automatic push(rec_t r);
        step(1'b1, r, 1'b0, 1'b0, 12'h0);
    endtask

    task automatic rdw(logic [11:0] a);
        step(1'b0, '0, 1'b0, 1'b1, a);
    endtask

    task automatic step32(bit s, bit rdo, logic [11:0] a);
        n_stb = s; n_rd = rdo; n_ra = a;
        @(negedge clk);
        last = n_rdata;
        n_stb = 1'b0; n_rd = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R9 irq after reset", 32'(irq), 32'h0);
        chk("R9 ovf after reset", 32'(ovf), 32'h0);
        rdw(12'h190); chk("R9 status after reset", last, 32'h0);
        chk("R2 read valid strobe", 32'(rvld), 32'h1);
        rdw(12'h1AC); chk("R9 pop on empty data", last, 32'h0);
        rdw(12'h190); chk("R9 status after empty pop", last, 32'h0);

        // Table walk: capture all records, then read each one out
        foreach (VEC[i]) push(VEC[i]);
        chk("R7 irq after capture", 32'(irq), 32'h1);
        chk("R5 no ovf at depth", 32'(ovf), 32'h0);
        rdw(12'h1B0); chk("R2 unmapped above window", last, 32'h0);
        rdw(12'h18C); chk("R2 unmapped below window", last, 32'h0);
        foreach (VEC[i]) begin
            for (int k = 0; k < 7; k++) begin
                rdw(OFS[k]);
                chk($sformatf("R1 R2 rec%0d ofs %h", i, OFS[k]), last,
                    expw(VEC[i], OFS[k], 1'b1));
            end
            rdw(12'h190);
            chk($sformatf("R3 no pop before last word rec%0d", i), last,
                expw(VEC[i], 12'h190, 1'b1));
            rdw(12'h1AC);
            chk($sformatf("R3 pop word rec%0d", i), last,
                expw(VEC[i], 12'h1AC, 1'b1));
        end
        rdw(12'h190); chk("R9 status after drain", last, 32'h0);

        // Overflow: fifth record is dropped
        foreach (VEC[i]) push(VEC[i]);
        push(EXTRA);
        chk("R5 ovf set on drop", 32'(ovf), 32'h1);
        foreach (VEC[i]) begin
            rdw(12'h194); chk($sformatf("R5 order rec%0d", i), last, {24'b0, VEC[i].id});
            rdw(12'h1AC);
        end
        rdw(12'h190); chk("R5 dropped record absent", last, 32'h0);
        chk("R5 ovf sticky", 32'(ovf), 32'h1);

        // Clear pulse
        step(1'b0, '0, 1'b1, 1'b0, 12'h0);
        chk("R7 irq cleared", 32'(irq), 32'h0);
        chk("R7 ovf cleared", 32'(ovf), 32'h0);

        // Capture and removal in the same cycle at full
        foreach (VEC[i]) push(VEC[i]);
        step(1'b1, EXTRA, 1'b0, 1'b1, 12'h1AC);
        chk("R6 popped word", last, VEC[0].wd[127:96]);
        chk("R6 no ovf", 32'(ovf), 32'h0);
        for (int i = 1; i < 4; i++) begin
            rdw(12'h194); chk($sformatf("R6 order rec%0d", i), last, {24'b0, VEC[i].id});
            rdw(12'h1AC);
        end
        rdw(12'h194); chk("R6 new record kept", last, {24'b0, EXTRA.id});
        rdw(12'h1AC);
        rdw(12'h190); chk("R6 empty after drain", last, 32'h0);

        // Valid gating by the interrupt flag
        push(VEC[0]);
        step(1'b0, '0, 1'b1, 1'b0, 12'h0);
        rdw(12'h190); chk("R8 valid hidden by clear", last, expw(VEC[0], 12'h190, 1'b0));
        push(VEC[1]);
        rdw(12'h190); chk("R8 valid back, head kept", last, expw(VEC[0], 12'h190, 1'b1));
        step(1'b1, VEC[2], 1'b1, 1'b0, 12'h0);
        chk("R7 set wins over clear", 32'(irq), 32'h1);
        rdw(12'h190); chk("R8 valid after set-and-clear", last, expw(VEC[0], 12'h190, 1'b1));
        repeat (3) rdw(12'h1AC);
        rdw(12'h190); chk("R8 empty clears valid", last, 32'h0);

        // Narrow instance: 32-bit address and data
        step32(1'b1, 1'b0, 12'h0);
        step32(1'b0, 1'b1, 12'h198); chk("R2 narrow addr low", last, VEC[0].ad[31:0]);
        step32(1'b0, 1'b1, 12'h19C); chk("R4 narrow addr high zero", last, 32'h0);
        step32(1'b0, 1'b1, 12'h1A4); chk("R4 data above width zero", last, 32'h0);
        step32(1'b0, 1'b1, 12'h1A0); chk("R3 narrow pop word", last, VEC[0].wd[31:0]);
        step32(1'b0, 1'b1, 12'h190); chk("R3 narrow queue emptied", last, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule